// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the internal access address for a synchronous burst memory. On a clock edge that is enabled and has the load/advance control low, it takes a complete external address. On an enabled edge with that control high, it steps to the next beat of a four-beat burst. Only the two least significant address bits move during a burst. The upper bits keep the value that was loaded.

A static order input picks one of two burst orders. Linear order counts up from the loaded seed, modulo four. Interleaved order XORs the seed with the beat number. The order input is meant to be tied high when it is not driven, which selects interleaved order.

An active-low clock enable masks clock edges. While it is high, every register keeps its value. Advancing does not depend on any select or write control, because the block has none. A beat index output gives the position within the current burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, that edge clears the state, so `cur_addr` reads 0 and `beat_idx` reads 0. Reset takes priority over the clock enable.
- R2: An edge with `clk_en_n`=0 and `load_n`=0 loads the address. After that edge, `cur_addr` equals the sampled `ext_addr` and `beat_idx` is 0.
- R3: An edge with `clk_en_n`=0 and `load_n`=1 adds one to `beat_idx`, modulo 4.
- R4: With `order_sel`=0 (linear), bits [1:0] of `cur_addr` equal (seed + `beat_idx`) mod 4. The seed is bits [1:0] of the last loaded address, so seed 1 gives the sequence 1,2,3,0.
- R5: With `order_sel`=1 (interleaved), bits [1:0] of `cur_addr` equal seed XOR `beat_idx`, so seed 1 gives the sequence 1,0,3,2.
- R6: An advance never changes bits [ADDR_W-1:2] of `cur_addr`. The low bits wrap from 3 to 0 with no carry into the upper bits.
- R7: An edge with `clk_en_n`=1 changes nothing. `cur_addr` and `beat_idx` hold, whatever `load_n` and `ext_addr` show.
- R8: After four advances with no load between them, `cur_addr` is back at the loaded address and `beat_idx` is 0. Further advances repeat the same four-beat cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high masks the edge |
| load_n | input | 1 | Low loads `ext_addr`, high advances the burst |
| ext_addr | input | ADDR_W | External address sampled on a load |
| order_sel | input | 1 | 0 = linear order, 1 = interleaved order (tie high if unused) |
| cur_addr | output | ADDR_W | Current internal access address |
| beat_idx | output | 2 | Beat number within the current burst |

## Verification
The hardest situation to reach is a burst that is interrupted by masked edges and then resumes. The wrap must land correctly even when the seed is not zero and the upper bits are all ones. In that case any carry out of the low bits would become visible.

The random stimulus produces long runs of advances, and it scatters clock-enable-high cycles between them. It also presents load-low values and new addresses during stalled edges, which must have no effect. Directed cases load an address with all upper bits set and seed 3. They then walk the full burst in both orders and confirm that the loaded address returns.

// File: rtl/burst_seq_pkg.sv
// Package: shared types and widths for the burst address sequencer.
// Assumes: a burst is 2**BEAT_W beats long.
package burst_seq_pkg;

    // Burst order selected by the static order input.
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    // Action taken at one clock edge.
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_LOAD    = 2'd1,
        ACT_ADVANCE = 2'd2
    } seq_action_e;

endpackage

// File: rtl/burst_beat_ctr.sv
// Module: beat counter for one burst.
// Clears on a load and steps by one on an advance, wrapping at 2**BEAT_W.
// Assumes: the action input is already qualified by the clock enable.
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_action_e       action,
    output logic [BEAT_W-1:0] beat
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    // Purpose: hold, clear or increment the beat number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beat <= '0;
        end else begin
            case (action)
                ACT_LOAD:    beat <= '0;
                ACT_ADVANCE: beat <= beat + ONE;
                default:     beat <= beat;
            endcase
        end
    end

endmodule

// File: rtl/burst_addr_reg.sv
// Module: base address register.
// Captures the upper address bits and the low seed bits on a load.
// Assumes: ADDR_W > BEAT_W. Advances never touch this register.
module burst_addr_reg
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_action_e              action,
    input  logic [ADDR_W-1:0]        addr_in,
    output logic [ADDR_W-1:BEAT_W]   upper,
    output logic [BEAT_W-1:0]        seed
);

    // Purpose: latch the base address on a load, otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upper <= '0;
            seed  <= '0;
        end else if (action == ACT_LOAD) begin
            upper <= addr_in[ADDR_W-1:BEAT_W];
            seed  <= addr_in[BEAT_W-1:0];
        end
    end

endmodule

// File: rtl/burst_order_map.sv
// Module: maps seed and beat number to the low address bits.
// Linear order: seed + beat (wraps). Interleaved order: seed XOR beat.
// Assumes: the order select is static, or changes only between bursts.
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] seed,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] low
);

    logic [BEAT_W-1:0] lin_low;
    logic [BEAT_W-1:0] ilv_low;
    logic [BEAT_W:0]   carry;

    assign carry[0] = 1'b0;

    // Ripple adder for linear order. The carry out of the top bit is dropped,
    // so the count wraps.
    for (genvar i = 0; i < BEAT_W; i++) begin : g_bit
        assign lin_low[i]  = seed[i] ^ beat[i] ^ carry[i];
        assign carry[i+1]  = (seed[i] & beat[i]) | (carry[i] & (seed[i] ^ beat[i]));
        assign ilv_low[i]  = seed[i] ^ beat[i];
    end

    // Purpose: pick the burst order.
    always_comb begin
        low = (order == ORD_INTERLEAVE) ? ilv_low : lin_low;
    end

    logic unused_carry;
    assign unused_carry = carry[BEAT_W];

endmodule

// File: rtl/burst_addr_seq.sv
// Module: top of the burst address sequencer.
// A load captures an external address. An advance steps the low BEAT_W bits
// through a 2**BEAT_W beat burst in linear or interleaved order. An active-low
// clock enable freezes all state.
// Assumes: order_sel is tied high when unused (interleaved).
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              load_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [BEAT_W-1:0] beat_idx
);

    seq_action_e           action;
    logic [ADDR_W-1:BEAT_W] upper;
    logic [BEAT_W-1:0]      seed;
    logic [BEAT_W-1:0]      low;
    burst_order_e           order;

    // Purpose: decode the edge action from the clock enable and load control.
    always_comb begin
        if (clk_en_n)     action = ACT_HOLD;
        else if (!load_n) action = ACT_LOAD;
        else              action = ACT_ADVANCE;
    end

    assign order = burst_order_e'(order_sel);

    burst_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .action  (action),
        .addr_in (ext_addr),
        .upper   (upper),
        .seed    (seed)
    );

    burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
        .clk    (clk),
        .rst_n  (rst_n),
        .action (action),
        .beat   (beat_idx)
    );

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .seed  (seed),
        .beat  (beat_idx),
        .order (order),
        .low   (low)
    );

    assign cur_addr = {upper, low};

endmodule

// File: rtl/burst_addr_seq_chk.sv
// Checker: port-level properties of burst_addr_seq, attached with bind.
module burst_addr_seq_chk #(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              load_n,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              order_sel,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [BEAT_W-1:0] beat_idx
);

    localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && !load_n) |=> (cur_addr == $past(ext_addr) && beat_idx == '0)); // R2

    AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> (beat_idx == $past(beat_idx) + ONE)); // R3

    AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n && !order_sel) |=>
        (order_sel || cur_addr[BEAT_W-1:0] == $past(cur_addr[BEAT_W-1:0]) + ONE)); // R4

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_n && load_n) |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]))); // R6

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(beat_idx) && (cur_addr == $past(cur_addr) || order_sel != $past(order_sel)))); // R7

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .load_n    (load_n),
    .ext_addr  (ext_addr),
    .order_sel (order_sel),
    .cur_addr  (cur_addr),
    .beat_idx  (beat_idx)
);

// File: tb/test_burst_addr_seq.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// a reference model written from the requirements.
module test_burst_addr_seq;

    localparam int ADDR_W = 17;
    localparam int BEAT_W = 2;
    localparam int MAX_CYC = 20000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              clk_en_n = 1'b0;
    logic              load_n = 1'b0;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              order_sel = 1'b1;
    logic [ADDR_W-1:0] cur_addr;
    logic [BEAT_W-1:0] beat_idx;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // Reference state
    logic [ADDR_W-1:0] m_base = '0;
    logic [1:0]        m_beat = '0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_burst_addr_seq (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .load_n(load_n),
        .ext_addr(ext_addr), .order_sel(order_sel),
        .cur_addr(cur_addr), .beat_idx(beat_idx)
    );

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] base,
                                                   input logic [1:0] beat, input logic ord);
        logic [1:0] lo;
        lo = ord ? (base[1:0] ^ beat) : (base[1:0] + beat);
        return {base[ADDR_W-1:2], lo};
    endfunction

    task automatic check(input string req);
        logic [ADDR_W-1:0] ea;
        ea = exp_addr(m_base, m_beat, order_sel);
        vectors++;
        if (cur_addr !== ea || beat_idx !== m_beat) begin
            errors++;
            $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
                     req, cur_addr, beat_idx, ea, m_beat);
        end
    endtask

    // Drive at the falling edge, update the model at the rising edge,
    // compare at the next falling edge.
    task automatic step(input logic rst_v, input logic en_n, input logic ld_n,
                        input logic [ADDR_W-1:0] a, input logic ord, input string req);
        rst_n = rst_v; clk_en_n = en_n; load_n = ld_n; ext_addr = a; order_sel = ord;
        @(posedge clk);
        cycles++;
        if (!rst_v) begin
            m_base = '0; m_beat = '0;
        end else if (!en_n) begin
            if (!ld_n) begin m_base = a; m_beat = '0; end
            else m_beat = m_beat + 2'd1;
        end
        @(negedge clk);
        check(req);
    endtask

    // Watchdog
    initial begin
        repeat (MAX_CYC * 2) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd1217);
        @(negedge clk);
        // R1: reset state, with clock enable high to show reset priority
        step(1'b0, 1'b1, 1'b0, 17'h1ABCD, 1'b1, "R1");
        step(1'b0, 1'b0, 1'b0, 17'h0F0F3, 1'b0, "R1");

        // R2 load, then R4 linear burst seed 1 with R8 wrap
        step(1'b1, 1'b0, 1'b0, 17'h12345, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, 1'b0, "R4_R8");
        for (int i = 0; i < 2; i++) step(1'b1, 1'b0, 1'b1, '0, 1'b0, "R8");

        // R5 interleaved burst seed 1
        step(1'b1, 1'b0, 1'b0, 17'h0AAA1, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, 1'b1, "R5_R8");

        // R6 upper bits all ones, seed 3, both orders
        step(1'b1, 1'b0, 1'b0, 17'h1FFFF, 1'b0, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b0, 17'h1FFFF, 1'b1, "R2");
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, '0, 1'b1, "R6");

        // R7 stalls mid-burst with load low and a new address presented
        step(1'b1, 1'b0, 1'b0, 17'h00006, 1'b0, "R2");
        step(1'b1, 1'b0, 1'b1, '0, 1'b0, "R3");
        step(1'b1, 1'b1, 1'b0, 17'h15555, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b1, 17'h0AAAA, 1'b0, "R7");
        step(1'b1, 1'b0, 1'b1, '0, 1'b0, "R3");

        // Random mix; order changes only on loads
        begin
            logic ord;
            ord = 1'b1;
            for (int i = 0; i < 3000; i++) begin
                logic en_n, ld_n;
                en_n = ($urandom % 5) == 0;
                ld_n = ($urandom % 6) != 0;
                if (!en_n && !ld_n) ord = $urandom % 2;
                step(($urandom % 400) != 0, en_n, ld_n, ADDR_W'($urandom), ord, "R3_R7");
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule